// File: doc/BRIEF.md
# Pin-Change Interrupt Controller with Per-Pin Glitch Filter

This block watches a parameterised set of input pins (32 by default) and records every change of logic level on each of them in a change-status register. Every pin is first brought into the clock domain by a two-flop synchroniser. It then passes through a deglitcher that can be switched on for each pin separately. The cleaned levels are exported as `pins_filt`, and they are also what the change detector observes.

A single interrupt line is asserted while any recorded change sits on a pin whose interrupt enable is set. A small register port selects the deglitched pins and the interrupt-enabled pins through set/clear addresses, with a status address for each. It also returns the change-status register, which empties itself when read. Both edges count. A change is recorded no matter what the pin is used for elsewhere in the chip.

Top module: `pin_change_irq`

## Requirements
- R1: With its filter off, a level change on `pins_in[i]` shows on `pins_filt[i]` after exactly three rising clock edges (two synchroniser stages plus one output register).
- R2: With its filter on, a pin's new level is taken only after two consecutive synchronised samples both hold that level. A pulse lasting one clock is dropped, and a pulse lasting two clocks passes with a latency of four edges.
- R3: A write to 0x20 turns the filter on for every pin whose data bit is 1, and a write to 0x24 turns it off for every such pin. Zero bits change nothing. A read of 0x28 returns the filter selections, bit i for pin i.
- R4: A change-status bit becomes 1 on the same edge that its `pins_filt` bit changes, for rising and for falling changes alike. It stays at 1 until the status register is read.
- R5: A read of 0x4C returns the change-status register and clears it. If a change is recorded on the same edge as the read, the read returns the old value and the new change stays set afterwards.
- R6: A write to 0x40 sets the interrupt enable of every pin whose data bit is 1, and a write to 0x44 clears it. Zero bits change nothing. A read of 0x48 returns the enables.
- R7: `irq` is registered. It equals, one edge later, the OR over all pins of the status bit ANDed with the enable bit.
- R8: A pin with its enable cleared still records changes in the status register, but it never drives `irq`.
- R9: After reset, filter selections, enables, change status, `pins_filt`, `irq` and `bus_rdata` are all zero.
- R10: `bus_rdata` is registered and is valid one edge after `bus_rd`. It reads zero at unmapped addresses and in any cycle without a read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pins_in | input | NPINS | Asynchronous pin levels |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | NPINS | Write data, one bit per pin |
| bus_rdata | output | NPINS | Read data, registered |
| pins_filt | output | NPINS | Synchronised, optionally deglitched pin levels |
| irq | output | 1 | Interrupt request, registered |

## Verification
The assertions assume that reset is held for at least two clocks. This lets the filter check look two samples back without seeing values from before reset. They also assume that `bus_wr` and `bus_rd` carry a single address per cycle. The stimulus holds reset for four clocks and changes pins, addresses and strobes only on falling edges. It drives pins at level 0 before reset is released, so no change is recorded during reset. Pulses of one and two clocks are applied on purpose to probe the filter threshold, and one status read is timed to land on the same edge as a new change.

// File: rtl/pc_pkg.sv
package pc_pkg;
  parameter int unsigned ADDR_W = 8;
  typedef logic [ADDR_W-1:0] addr_t;

  localparam addr_t A_FLT_SET  = 8'h20;
  localparam addr_t A_FLT_CLR  = 8'h24;
  localparam addr_t A_FLT_STAT = 8'h28;
  localparam addr_t A_MSK_SET  = 8'h40;
  localparam addr_t A_MSK_CLR  = 8'h44;
  localparam addr_t A_MSK_STAT = 8'h48;
  localparam addr_t A_CHG_STAT = 8'h4C;
endpackage

// File: rtl/pc_sync.sv
module pc_sync #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1, stage2;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= '0;
      stage2 <= '0;
    end else begin
      stage1 <= d;
      stage2 <= stage1;
    end
  end

  assign q = stage2;
endmodule

// File: rtl/pc_filter.sv
module pc_filter #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  input  logic [W-1:0] fen,
  output logic [W-1:0] flt,
  output logic [W-1:0] chg
);
  logic [W-1:0] smp;
  logic [W-1:0] acc;
  logic [W-1:0] nxt;

  for (genvar i = 0; i < int'(W); i++) begin : g_bit
    always_comb begin
      if (fen[i]) nxt[i] = (din[i] == smp[i]) ? din[i] : acc[i];
      else        nxt[i] = din[i];
    end

    // R2
    filt_stable_chk: assert property (@(posedge clk) disable iff (rst)
      ($past(fen[i]) && (acc[i] != $past(acc[i])))
        |-> ((acc[i] == $past(din[i])) && (acc[i] == $past(din[i], 2))));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      smp <= '0;
      acc <= '0;
    end else begin
      smp <= din;
      acc <= nxt;
    end
  end

  assign flt = acc;
  assign chg = nxt ^ acc;
endmodule

// File: rtl/pc_chg_latch.sv
module pc_chg_latch #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] chg,
  input  logic         rd_clr,
  output logic [W-1:0] status
);
  always_ff @(posedge clk) begin
    if (rst) status <= '0;
    else     status <= (rd_clr ? '0 : status) | chg;
  end

  // R4
  chg_latched_chk: assert property (@(posedge clk) disable iff (rst)
    (|chg) |=> ((status & $past(chg)) == $past(chg)));

  // R5
  rd_clear_chk: assert property (@(posedge clk) disable iff (rst)
    rd_clr |=> ((status & ~$past(chg)) == '0));

  // R5
  sticky_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rd_clr) |-> (($past(status) & ~status) == '0));
endmodule

// File: rtl/pin_change_irq.sv
module pin_change_irq
  import pc_pkg::*;
#(
  parameter int unsigned NPINS = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPINS-1:0] pins_in,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [7:0]       bus_addr,
  input  logic [NPINS-1:0] bus_wdata,
  output logic [NPINS-1:0] bus_rdata,
  output logic [NPINS-1:0] pins_filt,
  output logic             irq
);
  localparam logic [NPINS-1:0] ZERO = '0;

  logic [NPINS-1:0] sync_q;
  logic [NPINS-1:0] fen;
  logic [NPINS-1:0] mask;
  logic [NPINS-1:0] chg;
  logic [NPINS-1:0] status;
  logic             rd_clr;

  pc_sync #(.W(NPINS)) u_sync (
    .clk(clk), .rst(rst), .d(pins_in), .q(sync_q)
  );

  pc_filter #(.W(NPINS)) u_filter (
    .clk(clk), .rst(rst), .din(sync_q), .fen(fen), .flt(pins_filt), .chg(chg)
  );

  assign rd_clr = bus_rd && (bus_addr == A_CHG_STAT);

  pc_chg_latch #(.W(NPINS)) u_latch (
    .clk(clk), .rst(rst), .chg(chg), .rd_clr(rd_clr), .status(status)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      fen  <= '0;
      mask <= '0;
    end else if (bus_wr) begin
      unique case (bus_addr)
        A_FLT_SET: fen  <= fen | bus_wdata;
        A_FLT_CLR: fen  <= fen & ~bus_wdata;
        A_MSK_SET: mask <= mask | bus_wdata;
        A_MSK_CLR: mask <= mask & ~bus_wdata;
        default:   ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      unique case (bus_addr)
        A_FLT_STAT: bus_rdata <= fen;
        A_MSK_STAT: bus_rdata <= mask;
        A_CHG_STAT: bus_rdata <= status;
        default:    bus_rdata <= ZERO;
      endcase
    end else begin
      bus_rdata <= ZERO;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |(status & mask);
  end

  // R6
  mask_set_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == A_MSK_SET) |=> ((mask & $past(bus_wdata)) == $past(bus_wdata)));

  // R6
  mask_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == A_MSK_CLR) |=> ((mask & $past(bus_wdata)) == ZERO));

  // R7
  irq_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(|(status & mask)));

  // R8
  irq_masked_chk: assert property (@(posedge clk) disable iff (rst)
    ((status & mask) == ZERO) |=> !irq);

  // R10
  rdata_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> (bus_rdata == ZERO));
endmodule

// File: tb/tb_pin_change_irq.sv
module tb_pin_change_irq;
  localparam int N = 32;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [N-1:0] pins_in = '0;
  logic         bus_wr = 1'b0;
  logic         bus_rd = 1'b0;
  logic [7:0]   bus_addr = '0;
  logic [N-1:0] bus_wdata = '0;
  logic [N-1:0] bus_rdata;
  logic [N-1:0] pins_filt;
  logic         irq;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  pin_change_irq #(.NPINS(N)) dut (
    .clk(clk), .rst(rst), .pins_in(pins_in), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pins_filt(pins_filt), .irq(irq)
  );

  // Behavioural model: level history per edge, updated from the requirements
  logic [N-1:0] hist[$];
  logic [N-1:0] m_fen, m_mk, m_st, m_flt, m_rd;
  logic         m_irq;

  always @(posedge clk) begin
    logic [N-1:0] din, prv, nf, ch, rv, st_n, fen_n, mk_n;
    if (rst) begin
      hist = '{'0, '0, '0};
      m_fen = '0; m_mk = '0; m_st = '0; m_flt = '0; m_rd = '0; m_irq = 1'b0;
    end else begin
      din = hist[1];
      prv = hist[2];
      for (int i = 0; i < N; i++)
        nf[i] = m_fen[i] ? ((din[i] == prv[i]) ? din[i] : m_flt[i]) : din[i];
      ch = nf ^ m_flt;
      rv = '0;
      if (bus_rd) begin
        case (bus_addr)
          8'h28: rv = m_fen;
          8'h48: rv = m_mk;
          8'h4C: rv = m_st;
          default: rv = '0;
        endcase
      end
      st_n = ((bus_rd && bus_addr == 8'h4C) ? '0 : m_st) | ch;
      fen_n = m_fen; mk_n = m_mk;
      if (bus_wr) begin
        case (bus_addr)
          8'h20: fen_n = m_fen | bus_wdata;
          8'h24: fen_n = m_fen & ~bus_wdata;
          8'h40: mk_n = m_mk | bus_wdata;
          8'h44: mk_n = m_mk & ~bus_wdata;
          default: ;
        endcase
      end
      m_irq = |(m_st & m_mk);
      m_rd = rv; m_st = st_n; m_flt = nf; m_fen = fen_n; m_mk = mk_n;
      hist.push_front(pins_in);
      void'(hist.pop_back());
    end
  end

  task automatic check(input logic [N-1:0] act, input logic [N-1:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      check(pins_filt, m_flt, "R1 R2 pins_filt");
      check({{(N-1){1'b0}}, irq}, {{(N-1){1'b0}}, m_irq}, "R7 irq");
      check(bus_rdata, m_rd, "R10 rdata");
    end
  end

  task automatic do_wr(input logic [7:0] a, input logic [N-1:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic do_rd(input logic [7:0] a, input logic [N-1:0] exp, input string tag);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    check(bus_rdata, exp, tag);
    bus_rd = 1'b0;
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] lfsr;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9 reset state
    check(pins_filt, '0, "R9 pins_filt");
    check({31'd0, irq}, 32'd0, "R9 irq");
    do_rd(8'h4C, '0, "R9 status");
    do_rd(8'h48, '0, "R9 mask");
    do_rd(8'h28, '0, "R9 filter");

    // R6 enables
    do_wr(8'h40, 32'h0000_00FF);
    do_wr(8'h44, 32'h0000_000F);
    do_rd(8'h48, 32'h0000_00F0, "R6 set/clear");
    do_wr(8'h40, 32'h0);
    do_rd(8'h48, 32'h0000_00F0, "R6 zero bits");

    // R3 filter selection
    do_wr(8'h20, 32'hFFFF_0000);
    do_wr(8'h24, 32'h00FF_0000);
    do_rd(8'h28, 32'hFF00_0000, "R3 set/clear");
    do_wr(8'h24, 32'h0);
    do_rd(8'h28, 32'hFF00_0000, "R3 zero bits");

    // R1 unfiltered latency
    pins_in[0] = 1'b1;
    @(negedge clk); @(negedge clk);
    check({31'd0, pins_filt[0]}, 32'd0, "R1 before third edge");
    @(negedge clk);
    check({31'd0, pins_filt[0]}, 32'd1, "R1 third edge");
    do_rd(8'h4C, 32'h1, "R4 rising");
    do_rd(8'h4C, 32'h0, "R5 cleared");

    // R7 enabled pin raises irq one edge after status
    pins_in[4] = 1'b1;
    repeat (4) @(negedge clk);
    check({31'd0, irq}, 32'd1, "R7 irq high");
    do_rd(8'h4C, 32'h10, "R5 read pin4");
    @(negedge clk);
    check({31'd0, irq}, 32'd0, "R7 irq low");

    // R8 disabled pin still latched
    pins_in[1] = 1'b1;
    repeat (5) @(negedge clk);
    check({31'd0, irq}, 32'd0, "R8 no irq");
    do_rd(8'h4C, 32'h2, "R8 status latched");

    // R5 change coinciding with read
    pins_in[2] = 1'b1;
    @(negedge clk); @(negedge clk);
    do_rd(8'h4C, 32'h0, "R5 same-edge old value");
    do_rd(8'h4C, 32'h4, "R5 same-edge kept");

    // R2 single-cycle pulse suppressed
    pins_in[24] = 1'b1;
    @(negedge clk);
    pins_in[24] = 1'b0;
    repeat (6) @(negedge clk);
    check({31'd0, pins_filt[24]}, 32'd0, "R2 pulse dropped");
    do_rd(8'h4C, 32'h0, "R2 no status");

    // R2 two-cycle pulse accepted after four edges
    pins_in[24] = 1'b1;
    @(negedge clk); @(negedge clk);
    pins_in[24] = 1'b0;
    @(negedge clk);
    check({31'd0, pins_filt[24]}, 32'd0, "R2 third edge");
    @(negedge clk);
    check({31'd0, pins_filt[24]}, 32'd1, "R2 fourth edge");
    repeat (4) @(negedge clk);
    check({31'd0, pins_filt[24]}, 32'd0, "R2 back low");
    do_rd(8'h4C, 32'h0100_0000, "R4 both edges one bit");

    // R4 falling edge
    pins_in[0] = 1'b0;
    repeat (3) @(negedge clk);
    do_rd(8'h4C, 32'h1, "R4 falling");

    // R10 unmapped
    do_rd(8'h00, 32'h0, "R10 unmapped 00");
    do_rd(8'h2C, 32'h0, "R10 unmapped 2C");

    // mixed traffic against the model
    lfsr = 32'hACE1_1234;
    for (int k = 0; k < 400; k++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      if (lfsr[3:0] < 4'd5) pins_in = pins_in ^ (32'h1 << lfsr[8:4]);
      if (lfsr[13:11] == 3'd0) begin
        bus_rd = 1'b1; bus_addr = 8'h4C;
      end else if (lfsr[13:11] == 3'd1) begin
        bus_wr = 1'b1; bus_addr = lfsr[14] ? 8'h40 : 8'h44; bus_wdata = lfsr;
      end else if (lfsr[13:11] == 3'd2) begin
        bus_wr = 1'b1; bus_addr = lfsr[15] ? 8'h20 : 8'h24; bus_wdata = ~lfsr;
      end
      @(negedge clk);
      bus_rd = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
    end
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule